// File: doc/BRIEF.md
# Reloadable Interval Timer with Interrupt Mask

This block is a byte-wide peripheral holding one down-counting interval timer and a five-source interrupt controller. A processor reaches it over a plain address/data bus with separate write and read strobes. The timer counts system clocks from a programmed reload value down to zero. On reaching zero it reloads, raises the timer flag, and either keeps running (continuous mode) or stops (one-shot mode).

The interrupt side holds a pending flag per source and a mask. The mask is updated in set/clear fashion: one data bit chooses whether the other written bits set or clear enables. Reading the status register returns the flags and wipes them in the same access. The active-low interrupt line is low whenever any enabled flag is pending. Four of the five sources are fed from a pulse input, so other event logic can be attached later; in this block only the timer drives a source of its own.

Top module: `interval_timer_regs`

## Requirements
- R1: After reset the counter and the reload latch are all ones, the control register reads 0x00, all flags and enables are clear, and `irq_n` is 1.
- R2: While control bit 0 (run) is 1, the counter drops by one on every clock. While run is 0, the counter holds its value.
- R3: Writes to address 0x4 and address 0x5 set the low and high bytes of the reload latch. Reads of the same addresses return the live counter low and high bytes. A high-byte write while stopped also loads the counter with {new high, latch low}; while running it changes only the latch.
- R4: In continuous mode (control bit 3 = 0), a running counter at zero reloads from the latch on the next clock, giving a period of latch+1 clocks, and sets flag bit 0.
- R5: In one-shot mode (control bit 3 = 1), the underflow reloads the counter, sets flag bit 0 and clears run, so the counter then stays at the latch value.
- R6: Writing control (address 0xE) with bit 4 = 1 loads the latch into the counter at once. Bit 4 always reads as 0, while bits 0 and 3 read back as written.
- R7: A write to address 0xD with bit 7 = 1 sets the enables selected by 1s in bits 0-4, and with bit 7 = 0 it clears them. 0x81 enables the timer source and 0x7F disables all five.
- R8: A read of address 0xD returns the flags in bits 0-4, 1 in bit 7 if any enabled flag is pending, and 0 in bits 5-6. The read clears all flags, and `irq_n` is 1 in the following cycle.
- R9: `irq_n` is 0 exactly while some flag and its enable are both 1. A mask write takes effect from the next cycle.
- R10: A flag whose source fires in the same cycle as a clearing status read stays pending after that read.
- R11: A pulse on `aux_evt[i]` sets flag bit i+1, whatever the mask holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the count clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| rdata | output | 8 | Read data, valid while rd_en is high |
| aux_evt | input | 4 | Event pulses for interrupt sources 1 to 4 |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Internal faults show up at the ports quickly. A counter that steps wrongly, or that reloads one cycle early or late, shifts the live count readback at once, and it shifts the first low cycle of `irq_n` by whole clocks. A wrong mask bit shows as `irq_n` staying high, or going low, in the cycle after a source pulse. A lost or stale flag shows in bits 0-4 and bit 7 of the next status read. The timing sweeps therefore compare the counter against latch-minus-elapsed-cycles on every clock, and they compare the interrupt onset against latch+1 clocks.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

    // Register offsets; software decodes these, so they are fixed
    localparam logic [3:0] ADR_CNT_LO = 4'h4;
    localparam logic [3:0] ADR_CNT_HI = 4'h5;
    localparam logic [3:0] ADR_ICR    = 4'hD;
    localparam logic [3:0] ADR_CTRL   = 4'hE;

    // Control register bit positions
    localparam int CTL_RUN     = 0;
    localparam int CTL_ONESHOT = 3;
    localparam int CTL_LOAD    = 4;

    // Interrupt control register: set/clear selector position
    localparam int ICR_SETCLR  = 7;

endpackage

// File: rtl/itmr_counter.sv
module itmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] latch_i,
    input  logic             load_i,
    input  logic             ctrl_wr_i,
    input  logic             run_wr_i,
    input  logic             oneshot_wr_i,
    output logic [CNT_W-1:0] count_o,
    output logic             run_o,
    output logic             oneshot_o,
    output logic             uflow_o
);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             run;
        logic             oneshot;
    } cnt_state_t;

    cnt_state_t s_d, s_q;
    logic       at_zero;

    always_comb begin
        s_d     = s_q;
        at_zero = (s_q.count == '0);
        uflow_o = s_q.run && at_zero;

        if (s_q.run) begin
            if (at_zero) begin
                s_d.count = latch_i;
                if (s_q.oneshot) begin
                    s_d.run = 1'b0;
                end
            end else begin
                s_d.count = s_q.count - 1'b1;
            end
        end

        if (ctrl_wr_i) begin
            s_d.run     = run_wr_i;
            s_d.oneshot = oneshot_wr_i;
        end

        if (load_i) begin
            s_d.count = latch_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.count   <= '1;
            s_q.run     <= 1'b0;
            s_q.oneshot <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign count_o   = s_q.count;
    assign run_o     = s_q.run;
    assign oneshot_o = s_q.oneshot;

    // R2: running counter above zero steps down by exactly one
    p_step_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.run && s_q.count != '0 && !load_i)
        |=> (s_q.count == $past(s_q.count) - 1'b1));

    // R2: stopped counter holds unless a load is requested
    p_hold_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.run && !load_i) |=> $stable(s_q.count));

    // R4: underflow reloads from the latch
    p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.run && s_q.count == '0) |=> (s_q.count == $past(latch_i)));

    // R5: one-shot underflow stops the timer
    p_oneshot_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.run && s_q.oneshot && s_q.count == '0 && !ctrl_wr_i) |=> !s_q.run);

endmodule

// File: rtl/itmr_intctl.sv
module itmr_intctl #(
    parameter int N_SRC = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic             setclr_i,
    input  logic [N_SRC-1:0] sel_i,
    input  logic             rd_clr_i,
    input  logic [N_SRC-1:0] set_i,
    output logic [N_SRC-1:0] flags_o,
    output logic             pending_o
);

    typedef struct packed {
        logic [N_SRC-1:0] mask;
        logic [N_SRC-1:0] flags;
    } ic_state_t;

    ic_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_i) begin
            if (setclr_i) begin
                s_d.mask = s_q.mask | sel_i;
            end else begin
                s_d.mask = s_q.mask & ~sel_i;
            end
        end
        // A clearing read drops old flags, but same-cycle events survive
        s_d.flags = (rd_clr_i ? '0 : s_q.flags) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.mask  <= '0;
            s_q.flags <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign flags_o   = s_q.flags;
    assign pending_o = |(s_q.flags & s_q.mask);

    // R8: after a clearing read only freshly raised flags remain
    p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clr_i |=> ((s_q.flags & ~$past(set_i)) == '0));

    // R10: an event is never lost, even during a clearing read
    p_event_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((s_q.flags & $past(set_i)) == $past(set_i)));

    // R7: set-style write turns the selected enables on
    p_mask_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && setclr_i) |=> ((s_q.mask & $past(sel_i)) == $past(sel_i)));

    // R7: clear-style write turns the selected enables off
    p_mask_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !setclr_i) |=> ((s_q.mask & $past(sel_i)) == '0));

endmodule

// File: rtl/interval_timer_regs.sv
module interval_timer_regs
    import itmr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int N_SRC  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rdata,
    input  logic [N_SRC-2:0]  aux_evt,
    output logic              irq_n
);

    localparam int CNT_W = 2 * DATA_W;

    typedef struct packed {
        logic [DATA_W-1:0] lat_hi;
        logic [DATA_W-1:0] lat_lo;
    } top_state_t;

    top_state_t        s_d, s_q;
    logic [CNT_W-1:0]  latch_next;
    logic [CNT_W-1:0]  count;
    logic              running;
    logic              oneshot;
    logic              uflow;
    logic              wr_lo, wr_hi, wr_icr, wr_ctrl, rd_icr;
    logic              load_req;
    logic [N_SRC-1:0]  flags;
    logic [N_SRC-1:0]  set_evt;
    logic              pending;
    logic [DATA_W-1:0] icr_view;
    logic [DATA_W-1:0] ctrl_view;

    // Address decode
    always_comb begin
        wr_lo   = wr_en && (addr == ADR_CNT_LO);
        wr_hi   = wr_en && (addr == ADR_CNT_HI);
        wr_icr  = wr_en && (addr == ADR_ICR);
        wr_ctrl = wr_en && (addr == ADR_CTRL);
        rd_icr  = rd_en && (addr == ADR_ICR);
    end

    // Latch next state; the new value is visible to a same-cycle load
    always_comb begin
        s_d = s_q;
        if (wr_lo) s_d.lat_lo = wdata;
        if (wr_hi) s_d.lat_hi = wdata;
        latch_next = {s_d.lat_hi, s_d.lat_lo};
        load_req   = (wr_ctrl && wdata[CTL_LOAD]) || (wr_hi && !running);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.lat_hi <= '1;
            s_q.lat_lo <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    itmr_counter #(.CNT_W(CNT_W)) u_counter (
        .clk          (clk),
        .rst_n        (rst_n),
        .latch_i      (latch_next),
        .load_i       (load_req),
        .ctrl_wr_i    (wr_ctrl),
        .run_wr_i     (wdata[CTL_RUN]),
        .oneshot_wr_i (wdata[CTL_ONESHOT]),
        .count_o      (count),
        .run_o        (running),
        .oneshot_o    (oneshot),
        .uflow_o      (uflow)
    );

    assign set_evt = {aux_evt, uflow};

    itmr_intctl #(.N_SRC(N_SRC)) u_intctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (wr_icr),
        .setclr_i  (wdata[ICR_SETCLR]),
        .sel_i     (wdata[N_SRC-1:0]),
        .rd_clr_i  (rd_icr),
        .set_i     (set_evt),
        .flags_o   (flags),
        .pending_o (pending)
    );

    // Read mux
    always_comb begin
        icr_view                   = '0;
        icr_view[N_SRC-1:0]        = flags;
        icr_view[DATA_W-1]         = pending;
        ctrl_view                  = '0;
        ctrl_view[CTL_RUN]         = running;
        ctrl_view[CTL_ONESHOT]     = oneshot;
        rdata = '0;
        if (rd_en) begin
            unique case (addr)
                ADR_CNT_LO: rdata = count[DATA_W-1:0];
                ADR_CNT_HI: rdata = count[CNT_W-1:DATA_W];
                ADR_ICR:    rdata = icr_view;
                ADR_CTRL:   rdata = ctrl_view;
                default:    rdata = '0;
            endcase
        end
    end

    assign irq_n = ~pending;

    // R8: a status read with no new event releases the interrupt next cycle
    p_irq_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_icr && !uflow && aux_evt == '0) |=> irq_n);

    // R3: a high-byte write while stopped loads the counter
    p_hi_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && !running) |=> (count == $past(latch_next)));

endmodule

// File: tb/interval_timer_regs_test.sv
module interval_timer_regs_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rdata;
    logic [3:0] aux_evt = '0;
    logic       irq_n;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 0;

    interval_timer_regs uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata),
        .aux_evt(aux_evt), .irq_n(irq_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    // All bus tasks start and end at a falling edge
    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse(input logic [3:0] ev);
        aux_evt = ev;
        @(negedge clk);
        aux_evt = '0;
    endtask

    task automatic load_stopped(input logic [15:0] v);
        wr(4'hE, 8'h00);
        wr(4'h4, v[7:0]);
        wr(4'h5, v[15:8]);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got %0d expected below %0d", cyc, WATCHDOG);
            finish_run();
        end
    end

    initial begin
        logic [7:0] v, v2;
        int j;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq_n", {15'b0, irq_n}, 16'h1);
        rd(4'h4, v); check("R1 cnt lo", {8'h0, v}, 16'hFF);
        rd(4'h5, v); check("R1 cnt hi", {8'h0, v}, 16'hFF);
        rd(4'hE, v); check("R1 ctrl", {8'h0, v}, 16'h00);
        rd(4'hD, v); check("R1 status", {8'h0, v}, 16'h00);

        // R3 latch writes while stopped load the counter
        load_stopped(16'h1234);
        rd(4'h4, v); check("R3 cnt lo", {8'h0, v}, 16'h34);
        rd(4'h5, v); check("R3 cnt hi", {8'h0, v}, 16'h12);

        // R4 continuous reload sweep: count after k clocks = L - k mod (L+1)
        for (int L = 0; L <= 4; L++) begin
            load_stopped(16'(L));
            wr(4'hE, 8'h11);
            addr = 4'h4; rd_en = 1'b1;
            for (int k = 0; k < 2*L + 5; k++) begin
                #1 check("R4 reload sequence", {8'h0, rdata}, 16'(L - (k % (L + 1))));
                @(negedge clk);
            end
            rd_en = 1'b0;
            wr(4'hE, 8'h00);
            rd(4'hD, v); check("R4 flag0 set", {8'h0, v}, 16'h01);
        end

        // R2 count then stop: 10 clocks running, one more on the stop write
        load_stopped(16'h0200);
        wr(4'hE, 8'h01);
        repeat (10) @(negedge clk);
        wr(4'hE, 8'h00);
        rd(4'h4, v); check("R2 stopped lo", {8'h0, v}, 16'hF5);
        repeat (3) @(negedge clk);
        rd(4'h4, v2); check("R2 hold lo", {8'h0, v2}, 16'hF5);
        rd(4'h5, v); check("R2 hold hi", {8'h0, v}, 16'h01);

        // R6 control readback
        wr(4'hE, 8'h11);
        rd(4'hE, v); check("R6 ctrl reads run only", {8'h0, v}, 16'h01);
        wr(4'hE, 8'h00);
        rd(4'hD, v);

        // R7 R9 R11 R8 mask sweep over sources 1..4
        for (int m = 0; m < 16; m++) begin
            wr(4'hD, 8'h7F);
            wr(4'hD, 8'(8'h80 | (m << 1)));
            for (int s = 1; s <= 4; s++) begin
                pulse(4'(1 << (s - 1)));
                check("R9 irq follows mask", {15'b0, irq_n}, 16'(((m >> (s - 1)) & 1) ? 0 : 1));
                rd(4'hD, v);
                check("R11 R8 status value", {8'h0, v},
                      16'((1 << s) | ((((m >> (s - 1)) & 1) != 0) ? 8'h80 : 8'h00)));
                check("R8 irq released", {15'b0, irq_n}, 16'h1);
            end
        end

        // R7 0x7F disables everything
        wr(4'hD, 8'h9F);
        wr(4'hD, 8'h7F);
        pulse(4'hF);
        check("R7 all disabled irq", {15'b0, irq_n}, 16'h1);
        rd(4'hD, v); check("R7 flags without enable", {8'h0, v}, 16'h1E);

        // R9 enable while pending takes effect, disable releases
        pulse(4'h1);
        check("R9 masked pending", {15'b0, irq_n}, 16'h1);
        wr(4'hD, 8'h82);
        check("R9 unmask asserts", {15'b0, irq_n}, 16'h0);
        wr(4'hD, 8'h02);
        check("R9 remask releases", {15'b0, irq_n}, 16'h1);
        rd(4'hD, v); check("R9 flag still there", {8'h0, v}, 16'h02);

        // R10 event during the clearing read
        addr = 4'hD; rd_en = 1'b1; aux_evt = 4'h2;
        #1 check("R10 read before event", {8'h0, rdata}, 16'h00);
        @(negedge clk);
        rd_en = 1'b0; aux_evt = '0;
        rd(4'hD, v); check("R10 event kept", {8'h0, v}, 16'h04);

        // R5 one-shot sweep: interrupt after L+1 clocks, then stopped at L
        wr(4'hD, 8'h81);
        for (int L = 1; L <= 6; L++) begin
            load_stopped(16'(L));
            wr(4'hE, 8'h19);
            j = 0;
            while (irq_n && j < 50) begin
                @(negedge clk);
                j++;
            end
            check("R5 one-shot delay", 16'(j), 16'(L + 1));
            rd(4'hE, v); check("R5 run cleared", {8'h0, v}, 16'h08);
            repeat (3) @(negedge clk);
            rd(4'h4, v); check("R5 held at latch", {8'h0, v}, 16'(L));
            rd(4'hD, v); check("R5 status", {8'h0, v}, 16'h81);
        end
        wr(4'hD, 8'h01);

        // R3 high write while running updates only the latch; R6 force load
        load_stopped(16'h00F0);
        wr(4'hE, 8'h01);
        wr(4'h5, 8'h05);
        rd(4'h5, v); check("R3 running hi write no load", {8'h0, v}, 16'h00);
        wr(4'hE, 8'h10);
        rd(4'h5, v); check("R6 force load hi", {8'h0, v}, 16'h05);
        rd(4'h4, v); check("R6 force load lo", {8'h0, v}, 16'hF0);
        rd(4'hE, v); check("R6 load bit reads 0", {8'h0, v}, 16'h00);

        finish_run();
    end

endmodule